// File: doc/BRIEF.md
# Cherenkov Sector Coincidence Trigger

This block makes the trigger decision for one detector sector that is read by nine photomultipliers. All nine amplitude words arrive together under one valid strobe. Each word is first scaled by its own gain factor, which evens out the tubes. A scaled channel that lies above a low discriminator level marks that tube as hit. The hit then stays open for a programmable number of clock cycles, so that tubes firing a few cycles apart still count together.

On every sample the block adds up the nine scaled amplitudes. It fires the trigger only when two conditions hold at once: enough tubes are open, and the summed amplitude exceeds a second, higher level. The hit pattern and the sum leave the block registered beside the trigger, so later stages can forward them. The gains, both levels, the minimum tube count and the window length are static settings. Change them only while the block is held in reset.

Top module: `cher_coinc_trigger`

## Requirements
- R1: While `rst` is high, `trig`, `hit_pat` and `esum` are all zero, and every open hit window is closed.
- R2: A channel's scaled amplitude is floor(amp × gain / 256). The gain is unsigned, with 8 integer bits and 8 fraction bits. A result above 4095 is clipped to 4095.
- R3: A channel is hit on a valid sample only when its scaled amplitude is strictly greater than `lo_thr`. Equality does not count.
- R4: Let a channel be hit on the sample taken at edge m, with `win_len` = W. Its bit of `hit_pat` (bit i for channel i) is then set for the evaluations of edges m through m+W−1, and a later hit restarts the window. With W = 0 no bit is ever set.
- R5: `esum` is the sum of the nine scaled amplitudes of the most recent valid sample. It is 16 bits wide, so nine channels at 4095 (36855) do not overflow, and it holds its value between valid samples.
- R6: `trig` is high for the evaluation of a valid sample only if the number of set `hit_pat` bits is at least `mult_min` and `esum` is greater than `sum_thr`. It is never high for a cycle without a valid sample. Two is the intended minimum tube count.
- R7: `trig`, `hit_pat` and `esum` for the sample taken at clock edge n change on edge n+3.
- R8: Either condition alone does not fire. A single large tube fails the count condition, and several small tubes fail the sum condition.
- R9: A channel whose gain is zero adds nothing to `esum` and is never hit, whatever its amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| amp_valid | input | 1 | All nine amplitude words are valid this cycle |
| amp_flat | input | 108 | Channel i amplitude at bits [12i+11:12i] |
| gain_flat | input | 144 | Channel i gain (8.8 unsigned) at bits [16i+15:16i] |
| lo_thr | input | 12 | Per-channel hit level (scaled units) |
| sum_thr | input | 16 | Level the amplitude sum must exceed |
| mult_min | input | 4 | Minimum number of open channels |
| win_len | input | 8 | Coincidence window length in clock cycles |
| trig | output | 1 | Trigger decision |
| hit_pat | output | 9 | Open-window flags, bit i for channel i |
| esum | output | 16 | Scaled amplitude sum of the last valid sample |

## Verification
The hardest situation to reach from the ports is a coincidence made of tubes that fired on different samples. One tube's hit window must still be open when a later sample supplies the second tube and a large enough sum. The window must also have closed one cycle later. Directed sequences place two single-channel hits exactly W−1 and exactly W cycles apart. Seeded random phases with windows of 1, 4 and 8 cycles and sparse valid strobes then mix such cases with saturated gains and exact-threshold amplitudes.

// File: rtl/cher_trig_pkg.sv
package cher_trig_pkg;
  // Default fraction bits of a gain word.
  localparam int unsigned GAIN_FRAC_DEF = 8;

  // Bits needed to hold a count of 0..n.
  function automatic int unsigned count_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cher_gain_corr.sv
module cher_gain_corr #(
  parameter int AW = 12,
  parameter int GW = 16,
  parameter int GF = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] amp,
  input  logic [GW-1:0] gain,
  output logic [AW-1:0] corr
);
  localparam int PW = AW + GW;
  localparam int SCW = PW - GF;

  logic [PW-1:0]  prod;
  logic [SCW-1:0] scaled;

  always_comb begin
    prod   = PW'(amp) * PW'(gain);
    scaled = prod[PW-1:GF];
  end

  always_ff @(posedge clk) begin
    if (rst)
      corr <= '0;
    else if (|scaled[SCW-1:AW])
      corr <= '1;
    else
      corr <= scaled[AW-1:0];
  end
endmodule

// File: rtl/cher_hit_window.sv
module cher_hit_window #(
  parameter int AW = 12,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic [AW-1:0] corr,
  input  logic [AW-1:0] thr,
  input  logic [WW-1:0] win,
  output logic          open_flag
);
  logic [WW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (vld && (corr > thr))
      remain <= win;
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign open_flag = (remain != '0);
endmodule

// File: rtl/cher_coinc_trigger.sv
module cher_coinc_trigger
  import cher_trig_pkg::*;
#(
  parameter int NCH = 9,
  parameter int AW  = 12,
  parameter int GW  = 16,
  parameter int GF  = GAIN_FRAC_DEF,
  parameter int WW  = 8,
  localparam int SW = AW + $clog2(NCH),
  localparam int CW = count_bits(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              amp_valid,
  input  logic [NCH*AW-1:0] amp_flat,
  input  logic [NCH*GW-1:0] gain_flat,
  input  logic [AW-1:0]     lo_thr,
  input  logic [SW-1:0]     sum_thr,
  input  logic [CW-1:0]     mult_min,
  input  logic [WW-1:0]     win_len,
  output logic              trig,
  output logic [NCH-1:0]    hit_pat,
  output logic [SW-1:0]     esum
);
  // Stage 0: registered input samples.
  logic [NCH*AW-1:0] amp_q;
  logic              v0;
  // Stage 1: gain-corrected channels.
  logic [AW-1:0]     corr [NCH];
  logic              v1;
  // Stage 2: windows and sum.
  logic [NCH-1:0]    open_w;
  logic [SW-1:0]     sum_r;
  logic              v2;
  logic [SW-1:0]     sum_c;
  logic [CW-1:0]     open_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q <= '0;
      v0    <= 1'b0;
      v1    <= 1'b0;
      v2    <= 1'b0;
    end else begin
      amp_q <= amp_flat;
      v0    <= amp_valid;
      v1    <= v0;
      v2    <= v1;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    cher_gain_corr #(.AW(AW), .GW(GW), .GF(GF)) u_gain (
      .clk  (clk),
      .rst  (rst),
      .amp  (amp_q[ch*AW +: AW]),
      .gain (gain_flat[ch*GW +: GW]),
      .corr (corr[ch])
    );
    cher_hit_window #(.AW(AW), .WW(WW)) u_win (
      .clk       (clk),
      .rst       (rst),
      .vld       (v1),
      .corr      (corr[ch]),
      .thr       (lo_thr),
      .win       (win_len),
      .open_flag (open_w[ch])
    );
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < NCH; i++)
      sum_c = sum_c + SW'(corr[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      sum_r <= '0;
    else if (v1)
      sum_r <= sum_c;
  end

  always_comb begin
    open_cnt = '0;
    for (int i = 0; i < NCH; i++)
      open_cnt = open_cnt + CW'(open_w[i]);
  end

  // Stage 3: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      trig    <= 1'b0;
      hit_pat <= '0;
      esum    <= '0;
    end else begin
      trig    <= v2 && (open_cnt >= mult_min) && (sum_r > sum_thr);
      hit_pat <= open_w;
      esum    <= sum_r;
    end
  end
endmodule

// File: rtl/cher_trig_chk.sv
module cher_trig_chk #(
  parameter int NCH = 9,
  parameter int SW  = 16,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           amp_valid,
  input logic [CW-1:0]  mult_min,
  input logic [SW-1:0]  sum_thr,
  input logic           trig,
  input logic [NCH-1:0] hit_pat,
  input logic [SW-1:0]  esum
);
  // R6: a trigger traces back to a valid sample four sampled clocks earlier.
  p_trig_from_sample_r6: assert property (@(posedge clk) disable iff (rst)
    trig |-> $past(amp_valid, 4));

  // R6: the count condition holds at the outputs whenever the trigger is set.
  p_trig_count_r6: assert property (@(posedge clk) disable iff (rst)
    trig |-> ($countones(hit_pat) >= $past(mult_min)));

  // R6, R8: the sum condition holds at the outputs whenever the trigger is set.
  p_trig_sum_r8: assert property (@(posedge clk) disable iff (rst)
    trig |-> (esum > $past(sum_thr)));

  // R5: the sum moves only in response to a valid sample.
  p_sum_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(amp_valid, 4) |-> $stable(esum));

  // R4: a newly opened channel traces back to a valid sample.
  p_new_open_r4: assert property (@(posedge clk) disable iff (rst)
    ((hit_pat & ~$past(hit_pat)) != '0) |-> $past(amp_valid, 4));
endmodule

bind cher_coinc_trigger cher_trig_chk #(.NCH(NCH), .SW(SW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .amp_valid (amp_valid),
  .mult_min  (mult_min),
  .sum_thr   (sum_thr),
  .trig      (trig),
  .hit_pat   (hit_pat),
  .esum      (esum)
);

// File: tb/cher_coinc_trigger_test.sv
module cher_coinc_trigger_test;
  localparam int NCH = 9;
  localparam int AW  = 12;
  localparam int GW  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             amp_valid = 1'b0;
  logic [NCH*AW-1:0] amp_flat = '0;
  logic [NCH*GW-1:0] gain_flat = '0;
  logic [11:0]      lo_thr = '0;
  logic [15:0]      sum_thr = '0;
  logic [3:0]       mult_min = 4'd2;
  logic [7:0]       win_len = 8'd1;
  logic             trig;
  logic [8:0]       hit_pat;
  logic [15:0]      esum;

  cher_coinc_trigger uut (
    .clk(clk), .rst(rst), .amp_valid(amp_valid), .amp_flat(amp_flat),
    .gain_flat(gain_flat), .lo_thr(lo_thr), .sum_thr(sum_thr),
    .mult_min(mult_min), .win_len(win_len), .trig(trig),
    .hit_pat(hit_pat), .esum(esum)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int s0 = 0;
  bit done = 0;

  int amp [NCH];
  int gain [NCH];
  int last_hit [NCH];
  int held_sum = 0;

  logic       e_trig [4];
  logic [8:0] e_pat [4];
  logic [15:0] e_sum [4];

  function automatic int scaled(input int a, input int g);
    int p;
    p = (a * g) >>> 8;
    if (p > 4095) p = 4095;
    return p;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic clear_inputs();
    for (int c = 0; c < NCH; c++) amp[c] = 0;
    amp_valid = 1'b0;
  endtask

  task automatic do_reset(input int lo, input int sthr, input int mm, input int w);
    rst = 1'b1;
    clear_inputs();
    repeat (4) @(negedge clk);
    // R1: outputs cleared under reset
    chk("R1", "trig in reset", int'(trig), 0);
    chk("R1", "hit_pat in reset", int'(hit_pat), 0);
    chk("R1", "esum in reset", int'(esum), 0);
    lo_thr = 12'(lo); sum_thr = 16'(sthr); mult_min = 4'(mm); win_len = 8'(w);
    for (int c = 0; c < NCH; c++) begin
      gain_flat[c*GW +: GW] = 16'(gain[c]);
      last_hit[c] = -100000;
    end
    held_sum = 0;
    rst = 1'b0;
    s0 = cyc;
  endtask

  // Drive one edge with the current amp[] and amp_valid, then check.
  task automatic tick(input string tag);
    int sum, cnt, slot;
    logic [8:0] pat;
    for (int c = 0; c < NCH; c++) amp_flat[c*AW +: AW] = 12'(amp[c]);
    if (amp_valid) begin
      sum = 0;
      for (int c = 0; c < NCH; c++) begin
        sum += scaled(amp[c], gain[c]);
        if (scaled(amp[c], gain[c]) > int'(lo_thr)) last_hit[c] = cyc;
      end
      held_sum = sum;
    end
    pat = '0; cnt = 0;
    for (int c = 0; c < NCH; c++)
      if (cyc - last_hit[c] < int'(win_len)) begin pat[c] = 1'b1; cnt++; end
    slot = cyc % 4;
    e_trig[slot] = amp_valid && (cnt >= int'(mult_min)) && (held_sum > int'(sum_thr));
    e_pat[slot]  = pat;
    e_sum[slot]  = 16'(held_sum);
    @(posedge clk);
    @(negedge clk);
    if (cyc - 3 >= s0) begin
      slot = (cyc - 3) % 4;
      chk({tag, " R6"}, "trig", int'(trig), int'(e_trig[slot]));
      chk({tag, " R4"}, "hit_pat", int'(hit_pat), int'(e_pat[slot]));
      chk({tag, " R5"}, "esum", int'(esum), int'(e_sum[slot]));
    end
    cyc++;
  endtask

  task automatic idle(input string tag, input int n);
    clear_inputs();
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic one_sample(input string tag);
    amp_valid = 1'b1;
    tick(tag);
    clear_inputs();
  endtask

  task automatic random_phase(input string tag, input int lo, input int sthr,
                              input int mm, input int w, input int n);
    for (int c = 0; c < NCH; c++) gain[c] = $urandom_range(200, 320);
    gain[$urandom_range(0, 8)] = (($urandom_range(0, 1)) != 0) ? 0 : 16'hFFFF;
    do_reset(lo, sthr, mm, w);
    for (int k = 0; k < n; k++) begin
      amp_valid = ($urandom_range(0, 1) != 0);
      for (int c = 0; c < NCH; c++)
        amp[c] = ($urandom_range(0, 9) == 0) ? $urandom_range(400, 4095)
                                             : $urandom_range(0, 520);
      tick(tag);
    end
    idle(tag, 4);
  endtask

  initial begin
    void'($urandom(32'd20240709));
    for (int c = 0; c < NCH; c++) gain[c] = 256;

    // R2 R5: saturation and full-scale sum 36855
    for (int c = 0; c < NCH; c++) gain[c] = 16'hFFFF;
    do_reset(100, 36854, 2, 2);
    for (int c = 0; c < NCH; c++) amp[c] = 4095;
    one_sample("R2 R5");
    idle("R2 R5", 5);

    // R2: 1000*1.5 = 1500 and 1001*0.5 = 500, other gains 1.0
    for (int c = 0; c < NCH; c++) gain[c] = 256;
    gain[0] = 16'h0180; gain[1] = 16'h0080;
    do_reset(400, 1999, 2, 1);
    amp[0] = 1000; amp[1] = 1001;
    one_sample("R2");
    idle("R2", 4);

    // R3: equality with lo_thr is not a hit
    for (int c = 0; c < NCH; c++) gain[c] = 256;
    do_reset(500, 0, 1, 1);
    amp[2] = 500; amp[3] = 501;
    one_sample("R3");
    idle("R3", 4);

    // R8: one big tube, then several small tubes
    do_reset(100, 1000, 2, 2);
    amp[4] = 4095;
    one_sample("R8");
    idle("R8", 3);
    amp[0] = 200; amp[1] = 200; amp[2] = 200;
    one_sample("R8");
    idle("R8", 4);

    // R9: zero gain kills a huge amplitude
    gain[5] = 0;
    do_reset(100, 100, 1, 2);
    amp[5] = 4095; amp[6] = 150;
    one_sample("R9");
    idle("R9", 4);
    gain[5] = 256;

    // R4: two tubes W-1 apart coincide, W apart do not; W=0 never opens
    do_reset(100, 0, 2, 3);
    amp[0] = 300; one_sample("R4");
    idle("R4", 1);
    amp[1] = 300; one_sample("R4");
    idle("R4", 6);
    amp[0] = 300; one_sample("R4");
    idle("R4", 2);
    amp[1] = 300; one_sample("R4");
    idle("R4", 6);
    do_reset(100, 0, 1, 0);
    amp[0] = 4000; amp[1] = 4000; one_sample("R4");
    idle("R4", 4);

    // R6 R7: seeded random traffic under several settings
    random_phase("R7", 500, 2500, 2, 4, 3000);
    random_phase("R7", 450, 1500, 3, 1, 3000);
    random_phase("R7", 480, 3000, 1, 8, 3000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule